// File: doc/BRIEF.md
# LCD Sync and Active-Window Timing Generator

This block produces the line sync, frame sync and data-valid window for a 320 by 240 TFT panel. The panel is driven through an 8-bit parallel port, so each pixel is sent as two or three consecutive bytes. Every timing quantity is counted in port clock ticks. A mode input selects two clocks per pixel for 16-bit colour or three clocks per pixel for 24-bit colour. The panel side adds a fixed pipeline delay, so the first valid data clock of a line sits a few ticks after a whole pixel slot.

When enabled, both syncs are active-low pulses counted from one shared tick counter. The frame sync falls on the same clock as the line sync of the first line, so it is never later than the line sync. A data-enable strobe marks the active pixels of the lines that follow the vertical blanking lines. Alongside it the block gives the pixel index, the byte phase within the pixel and the current line number, so a downstream byte multiplexer can choose which colour byte to put on the port. Removing the enable returns everything to idle. The next enable starts again from the first clock of a frame.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is low, and on every clock after enable has been seen low, hs_n and vs_n are 1, de is 0, and pix_x, phase and line_y are 0.
- R2: A line lasts H_TOTAL_PIX×cpp clocks (default 336×cpp). hs_n is 0 for the first HS_PIX×cpp clocks of every line (default 2×cpp), where cpp is the clocks per pixel.
- R3: A frame has V_ACT+V_BLANK lines (default 240+4). vs_n is 0 for the first VS_PIX×cpp clocks of line 0 only (default 2×cpp), starting on the same clock on which hs_n falls.
- R4: de is 1 from clock START_PIX×cpp+delay of a line for H_ACT_PIX×cpp clocks (default 7×cpp+delay and 320×cpp). It is 1 only on lines V_BLANK and above.
- R5: While de is 1, phase counts 0,1,…,cpp−1 and then wraps, and pix_x goes up by one at each wrap, starting from pix_x=0, phase=0 on the first de clock. Both read 0 while de is 0.
- R6: mode_24=0 selects cpp=2 with a delay of DLY_2 (default 3), and mode_24=1 selects cpp=3 with a delay of DLY_3 (default 5). The mode is taken on the edge at which enable is first seen high. A change of mode_24 while running has no effect on any output until the next enable.
- R7: The first clock after enable is seen high is clock 0 of line 0, with hs_n and vs_n both 0. Every enable starts at that point, whatever state the previous run stopped in.
- R8: line_y gives the current line, 0 to V_ACT+V_BLANK−1. It steps on the clock after the last clock of a line and wraps to 0 after the last line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| mode_24 | input | 1 | 0: two clocks per pixel, 1: three clocks per pixel |
| hs_n | output | 1 | Line sync, active low |
| vs_n | output | 1 | Frame sync, active low |
| de | output | 1 | Data-valid window |
| pix_x | output | $clog2(H_ACT_PIX) | Active pixel index, 0 outside de |
| line_y | output | $clog2(V_ACT+V_BLANK) | Current line number |
| phase | output | 2 | Byte index within the pixel, 0 outside de |

## Verification
On the last clock of the last line, the line counter wraps and the frame counter wraps at the same time. The clock that follows must therefore show the line sync, the frame sync and line 0 together. The bench runs several whole frames in both modes, so this coincidence is met repeatedly. It also removes the enable on exactly that wrap clock and checks that the outputs go idle instead of starting a frame sync. A behavioural model, built from tick and line integers and derived from the requirements, predicts every output on every clock. It is compared between edges.

// File: rtl/lcd_tim_pkg.sv
// Package: shared types and helpers for the LCD timing generator.
// Assumes clocks-per-pixel is only ever 2 or 3.
package lcd_tim_pkg;

    // Pixel packing mode as seen on the mode pin
    typedef enum logic {
        PM_2CLK = 1'b0,
        PM_3CLK = 1'b1
    } pix_mode_e;

    // Clocks per pixel for a mode
    function automatic logic [1:0] cpp_of(input pix_mode_e m);
        return (m == PM_3CLK) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/lcd_line_timer.sv
// lcd_line_timer: horizontal tick counter for one line.
// Counts port clocks 0..period-1 while run is high and holds 0 otherwise.
// It flags the line-sync span and the active data window.
// Assumes: hs_len, win_start and win_stop all lie within period.
module lcd_line_timer #(
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] period,
    input  logic [HW-1:0] hs_len,
    input  logic [HW-1:0] win_start,
    input  logic [HW-1:0] win_stop,
    output logic [HW-1:0] hcnt,
    output logic          line_wrap,
    output logic          hs_on,
    output logic          win_on,
    output logic          win_last
);

    // Last tick of the line
    assign line_wrap = run && (hcnt == period - HW'(1));

    // Tick counter: advance, wrap at the period, clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (!run || line_wrap) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + HW'(1);
        end
    end

    // Span decodes relative to the current tick
    always_comb begin
        hs_on    = run && (hcnt < hs_len);
        win_on   = run && (hcnt >= win_start) && (hcnt < win_stop);
        win_last = run && (hcnt == win_stop - HW'(1));
    end

endmodule

// File: rtl/lcd_frame_timer.sv
// lcd_frame_timer: line counter and frame sync.
// Steps once per line wrap and returns to 0 after the last line.
// Drives the frame sync during the first vs_len ticks of line 0.
// Assumes: line_wrap is a single-cycle pulse from the line timer.
module lcd_frame_timer #(
    parameter int HW      = 10,
    parameter int V_ACT   = 240,
    parameter int V_BLANK = 4,
    localparam int VTOT   = V_ACT + V_BLANK,
    localparam int VW     = $clog2(VTOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          line_wrap,
    input  logic [HW-1:0] hcnt,
    input  logic [HW-1:0] vs_len,
    output logic [VW-1:0] vcnt,
    output logic          vs_on,
    output logic          visible
);

    localparam logic [VW-1:0] VLAST = VW'(VTOT - 1);
    localparam logic [VW-1:0] VFIRST_ACT = VW'(V_BLANK);

    // Line counter: step on each line wrap, wrap after the last line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (!run) begin
            vcnt <= '0;
        end else if (line_wrap) begin
            vcnt <= (vcnt == VLAST) ? '0 : vcnt + VW'(1);
        end
    end

    // Frame sync span and visible-line decode
    always_comb begin
        vs_on   = run && (vcnt == '0) && (hcnt < vs_len);
        visible = (vcnt >= VFIRST_ACT);
    end

endmodule

// File: rtl/lcd_pixel_phase.sv
// lcd_pixel_phase: byte phase and pixel index inside the data window.
// phase counts 0..cpp-1 and pix steps at each phase wrap.
// Both are cleared whenever the next tick lies outside the window.
// Assumes: cpp is 2 or 3 and stays constant while run is high.
module lcd_pixel_phase #(
    parameter int XW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          win_on,
    input  logic          win_last,
    input  logic [1:0]    cpp,
    output logic [1:0]    phase,
    output logic [XW-1:0] pix
);

    logic stepping;
    logic ph_wrap;

    // Advance only while the window continues into the next tick
    assign stepping = run && win_on && !win_last;
    assign ph_wrap  = (phase == cpp - 2'd1);

    // Phase and pixel counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            pix   <= '0;
        end else if (!stepping) begin
            phase <= '0;
            pix   <= '0;
        end else if (ph_wrap) begin
            phase <= '0;
            pix   <= pix + XW'(1);
        end else begin
            phase <= phase + 2'd1;
        end
    end

endmodule

// File: rtl/lcd_sync_gen.sv
// lcd_sync_gen: top of the LCD sync and active-window generator.
// Takes the mode when a run starts and derives the per-mode tick limits.
// Instantiates the line timer, the frame timer and the pixel-phase counter.
// Assumes: START_PIX*3+DLY_3+H_ACT_PIX*3 <= H_TOTAL_PIX*3, and the same holds for cpp=2.
module lcd_sync_gen
    import lcd_tim_pkg::*;
#(
    parameter int H_ACT_PIX   = 320,
    parameter int H_TOTAL_PIX = 336,
    parameter int HS_PIX      = 2,
    parameter int VS_PIX      = 2,
    parameter int START_PIX   = 7,
    parameter int DLY_2       = 3,
    parameter int DLY_3       = 5,
    parameter int V_ACT       = 240,
    parameter int V_BLANK     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en,
    input  logic                                mode_24,
    output logic                                hs_n,
    output logic                                vs_n,
    output logic                                de,
    output logic [$clog2(H_ACT_PIX)-1:0]        pix_x,
    output logic [$clog2(V_ACT+V_BLANK)-1:0]    line_y,
    output logic [1:0]                          phase
);

    localparam int HW = $clog2(H_TOTAL_PIX * 3 + 1);
    localparam int XW = $clog2(H_ACT_PIX);
    localparam int VW = $clog2(V_ACT + V_BLANK);

    // Per-mode tick limits, computed once from the parameters
    localparam logic [HW-1:0] PER_2  = HW'(H_TOTAL_PIX * 2);
    localparam logic [HW-1:0] PER_3  = HW'(H_TOTAL_PIX * 3);
    localparam logic [HW-1:0] HSL_2  = HW'(HS_PIX * 2);
    localparam logic [HW-1:0] HSL_3  = HW'(HS_PIX * 3);
    localparam logic [HW-1:0] VSL_2  = HW'(VS_PIX * 2);
    localparam logic [HW-1:0] VSL_3  = HW'(VS_PIX * 3);
    localparam logic [HW-1:0] WST_2  = HW'(START_PIX * 2 + DLY_2);
    localparam logic [HW-1:0] WST_3  = HW'(START_PIX * 3 + DLY_3);
    localparam logic [HW-1:0] WSP_2  = HW'(START_PIX * 2 + DLY_2 + H_ACT_PIX * 2);
    localparam logic [HW-1:0] WSP_3  = HW'(START_PIX * 3 + DLY_3 + H_ACT_PIX * 3);

    logic          running;
    pix_mode_e     mode_q;
    logic [1:0]    cpp;
    logic [HW-1:0] period, hs_len, vs_len, win_start, win_stop;
    logic [HW-1:0] hcnt;
    logic          line_wrap, hs_on, win_on, win_last;
    logic [VW-1:0] vcnt;
    logic          vs_on, visible;
    logic [1:0]    ph_raw;
    logic [XW-1:0] px_raw;

    // Run flag: follows enable one clock later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else begin
            running <= en;
        end
    end

    // Mode capture: follows the pin only while idle, frozen during a run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_2CLK;
        end else if (!running) begin
            mode_q <= pix_mode_e'(mode_24);
        end
    end

    // Limit selection by captured mode
    always_comb begin
        cpp = cpp_of(mode_q);
        if (mode_q == PM_3CLK) begin
            period    = PER_3;
            hs_len    = HSL_3;
            vs_len    = VSL_3;
            win_start = WST_3;
            win_stop  = WSP_3;
        end else begin
            period    = PER_2;
            hs_len    = HSL_2;
            vs_len    = VSL_2;
            win_start = WST_2;
            win_stop  = WSP_2;
        end
    end

    lcd_line_timer #(
        .HW (HW)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .period    (period),
        .hs_len    (hs_len),
        .win_start (win_start),
        .win_stop  (win_stop),
        .hcnt      (hcnt),
        .line_wrap (line_wrap),
        .hs_on     (hs_on),
        .win_on    (win_on),
        .win_last  (win_last)
    );

    lcd_frame_timer #(
        .HW      (HW),
        .V_ACT   (V_ACT),
        .V_BLANK (V_BLANK)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .line_wrap (line_wrap),
        .hcnt      (hcnt),
        .vs_len    (vs_len),
        .vcnt      (vcnt),
        .vs_on     (vs_on),
        .visible   (visible)
    );

    lcd_pixel_phase #(
        .XW (XW)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .win_on   (win_on),
        .win_last (win_last),
        .cpp      (cpp),
        .phase    (ph_raw),
        .pix      (px_raw)
    );

    // Output shaping: active-low syncs, window gating, idle zeroing
    always_comb begin
        hs_n   = ~hs_on;
        vs_n   = ~vs_on;
        de     = running && win_on && visible;
        pix_x  = de ? px_raw : '0;
        phase  = de ? ph_raw : 2'd0;
        line_y = running ? vcnt : '0;
    end

endmodule

// File: rtl/lcd_sync_gen_chk.sv
// lcd_sync_gen_chk: port-level properties of lcd_sync_gen, bound to every instance.
// Assumes: it sees the same clock and reset as the block.
module lcd_sync_gen_chk #(
    parameter int XW      = 9,
    parameter int VW      = 8,
    parameter int HS_PIX  = 2,
    parameter int VS_PIX  = 2,
    parameter int V_ACT   = 240,
    parameter int V_BLANK = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          hs_n,
    input logic          vs_n,
    input logic          de,
    input logic [XW-1:0] pix_x,
    input logic [VW-1:0] line_y,
    input logic [1:0]    phase
);

    // R1: idle outputs on the clock after enable is seen low
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hs_n && vs_n && !de && pix_x == '0 && line_y == '0 && phase == 2'd0));

    // R7: both syncs fall on the first clock of a run
    a_r7_start_syncs: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !$past(en)) |=> (!hs_n && !vs_n && line_y == '0));

    // R4: data valid only on lines after blanking
    a_r4_de_visible: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (line_y >= VW'(V_BLANK)));

    // R5: counters zero outside the window, phase bounded inside
    a_r5_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (phase == 2'd0 && pix_x == '0));

    a_r5_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (phase <= 2'd2));

    // R5: each window clock either advances phase or wraps to the next pixel
    a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (de && $past(de)) |->
            ((phase == $past(phase) + 2'd1 && pix_x == $past(pix_x)) ||
             (phase == 2'd0 && pix_x == $past(pix_x) + XW'(1))));

    // R8: line number stays inside the frame
    a_r8_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        line_y <= VW'(V_ACT + V_BLANK - 1));

    // R3: frame sync never leads or outlasts the line sync when it is no wider
    generate
        if (VS_PIX <= HS_PIX) begin : g_vs_in_hs
            a_r3_vs_inside_hs: assert property (@(posedge clk) disable iff (!rst_n)
                !vs_n |-> !hs_n);
        end
    endgenerate

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(
    .XW      ($clog2(H_ACT_PIX)),
    .VW      ($clog2(V_ACT + V_BLANK)),
    .HS_PIX  (HS_PIX),
    .VS_PIX  (VS_PIX),
    .V_ACT   (V_ACT),
    .V_BLANK (V_BLANK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .hs_n   (hs_n),
    .vs_n   (vs_n),
    .de     (de),
    .pix_x  (pix_x),
    .line_y (line_y),
    .phase  (phase)
);

// File: tb/tb_lcd_sync_gen.sv
// tb_lcd_sync_gen: compares the block against a behavioural model on every clock.
// Uses a scaled geometry so that whole frames in both modes fit in a short run.
module tb_lcd_sync_gen;

    localparam int HA = 4, HT = 9, HSP = 2, VSP = 2, SP = 2, D2 = 3, D3 = 5;
    localparam int VA = 3, VB = 2, VT = VA + VB;
    localparam int XW = $clog2(HA), VW = $clog2(VT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic mode_24 = 1'b0;
    logic hs_n, vs_n, de;
    logic [XW-1:0] pix_x;
    logic [VW-1:0] line_y;
    logic [1:0] phase;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Model state (register view)
    int m_run = 0, m_h = 0, m_v = 0, m_cpp = 2, m_wraps = 0;

    always #2 clk = ~clk;

    lcd_sync_gen #(
        .H_ACT_PIX(HA), .H_TOTAL_PIX(HT), .HS_PIX(HSP), .VS_PIX(VSP),
        .START_PIX(SP), .DLY_2(D2), .DLY_3(D3), .V_ACT(VA), .V_BLANK(VB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_24(mode_24),
        .hs_n(hs_n), .vs_n(vs_n), .de(de), .pix_x(pix_x),
        .line_y(line_y), .phase(phase)
    );

    // Model update on each edge: advance with old mode, then capture mode, then run
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_h = 0; m_v = 0; m_cpp = 2;
        end else begin
            if (m_run != 0) begin
                if (m_h == HT * m_cpp - 1) begin
                    m_h = 0;
                    if (m_v == VT - 1) begin
                        m_v = 0;
                        m_wraps++;
                    end else begin
                        m_v++;
                    end
                end else begin
                    m_h++;
                end
            end else begin
                m_h = 0; m_v = 0;
            end
            if (m_run == 0) m_cpp = mode_24 ? 3 : 2;
            m_run = en ? 1 : 0;
        end
    end

    task automatic cmp(input string req, input string nm, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, nm, cyc, act, exp);
        end
    endtask

    // Expected outputs from model state, compared between edges
    always @(negedge clk) begin
        int st, e_hs, e_vs, e_de, e_px, e_ph, e_ln;
        st   = SP * m_cpp + ((m_cpp == 3) ? D3 : D2);
        e_hs = (m_run != 0 && m_h < HSP * m_cpp) ? 0 : 1;
        e_vs = (m_run != 0 && m_v == 0 && m_h < VSP * m_cpp) ? 0 : 1;
        e_de = (m_run != 0 && m_v >= VB && m_h >= st && m_h < st + HA * m_cpp) ? 1 : 0;
        e_px = e_de ? (m_h - st) / m_cpp : 0;
        e_ph = e_de ? (m_h - st) % m_cpp : 0;
        e_ln = (m_run != 0) ? m_v : 0;
        if (m_run == 0) begin
            cmp("R1", "idle_hs_n", int'(hs_n), 1);
            cmp("R1", "idle_de", int'(de), 0);
        end else begin
            cmp("R2", "hs_n", int'(hs_n), e_hs);
            cmp("R3", "vs_n", int'(vs_n), e_vs);
            cmp("R4", "de", int'(de), e_de);
            cmp("R5", "pix_x", int'(pix_x), e_px);
            cmp("R5", "phase", int'(phase), e_ph);
            cmp("R8", "line_y", int'(line_y), e_ln);
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait until the model sits on the last tick of the frame
    task automatic wait_frame_end();
        while (!(m_run != 0 && m_v == VT - 1 && m_h == HT * m_cpp - 1)) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        wait_clk(50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        wait_clk(3);
        cmp("R1", "reset_hs_n", int'(hs_n), 1);
        cmp("R1", "reset_vs_n", int'(vs_n), 1);
        cmp("R1", "reset_line_y", int'(line_y), 0);
        rst_n = 1'b1;
        wait_clk(3);

        // R6, R7: 2-clock mode start, both syncs low on the first run clock
        mode_24 = 1'b0; en = 1'b1;
        wait_clk(2);
        cmp("R7", "first_hs_n", int'(hs_n), 0);
        cmp("R7", "first_vs_n", int'(vs_n), 0);
        wait_clk(HT * 2 * VT * 2);
        cmp("R3", "frame_wraps_2clk", m_wraps >= 2 ? 1 : 0, 1);

        // R6: mode change while running is ignored
        mode_24 = 1'b1;
        wait_clk(HT * 2 * VT + 7);
        cmp("R6", "cpp_frozen", m_cpp, 2);

        // R1: disable, idle on the next clock
        en = 1'b0;
        wait_clk(2);
        cmp("R1", "off_vs_n", int'(vs_n), 1);
        cmp("R1", "off_line_y", int'(line_y), 0);
        wait_clk(4);

        // R6: 3-clock mode for two frames
        en = 1'b1;
        wait_clk(2);
        cmp("R6", "cpp_three", m_cpp, 3);
        cmp("R7", "restart_vs_n", int'(vs_n), 0);
        wait_clk(HT * 3 * VT * 2 + 5);

        // R3, R8: disable on exactly the frame wrap clock
        wait_frame_end();
        en = 1'b0;
        wait_clk(1);
        cmp("R1", "wrap_off_vs_n", int'(vs_n), 1);
        cmp("R1", "wrap_off_hs_n", int'(hs_n), 1);
        wait_clk(3);

        // R7: restart in 2-clock mode right after a 3-clock run
        mode_24 = 1'b0; en = 1'b1;
        wait_clk(2);
        cmp("R7", "restart2_hs_n", int'(hs_n), 0);
        // R3: let the frame wrap happen with syncs and line 0 together
        wait_frame_end();
        wait_clk(1);
        cmp("R3", "wrap_vs_n", int'(vs_n), 0);
        cmp("R8", "wrap_line_y", int'(line_y), 0);

        // R7: short enable pulses
        for (int k = 0; k < 3; k++) begin
            en = 1'b0; wait_clk(1 + k);
            en = 1'b1; wait_clk(5 + k);
        end

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        wait_clk(2);
        cmp("R1", "midrun_reset_hs_n", int'(hs_n), 1);
        rst_n = 1'b1; en = 1'b0;
        wait_clk(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule